// File: doc/BRIEF.md
# Converter Result Buffer and Status Unit

This block sits between an external 12-bit analog-to-digital converter and a 16-bit register bus on a data-acquisition card. Software writes a strobe address to start one conversion. The block sends a single-cycle start pulse to the converter and marks itself busy. When the converter reports completion, the block captures the result into a small first-in first-out buffer. Software drains that buffer through a read-only data port. A second strobe address flushes the buffer and clears the error flags.

A status word shows whether a sample is waiting, whether a conversion is still pending, and two sticky errors. The first error is that the buffer filled and a result was lost. The second is that a new start arrived while a conversion was still pending. A coding bit selects straight binary or two's-complement output; in two's-complement mode bit 11 of each word is inverted when it is read. A level-sensitive interrupt tells software that results are waiting, but only when two separate enable bits are both set.

Register map (word addresses on `addr_i`): 0 = status on read, control word on write; 1 = interrupt-gate word (write); 2 = start strobe (write); 3 = flush strobe (write); 4 = result port (read). All other addresses read zero, and writes to them have no effect.

Top module: `adc_acq_front`

## Requirements
- R1: After reset the status word reads 0x0000, `irq_o` and `conv_start_o` are low, both control words are zero, and so the coding is two's-complement and the interrupt is off.
- R2: A write of any data to address 2 while no conversion is pending drives `conv_start_o` high for exactly the next cycle. The same write sets status bit 11 (pending), and that bit stays set until `conv_done_i` is accepted.
- R3: A write to address 2 while a conversion is pending, in a cycle without `conv_done_i`, produces no start pulse and sets status bit 8 (overrun). Bit 8 stays set until a flush.
- R4: `conv_done_i` while a conversion is pending stores `conv_data_i` and clears the pending bit. Status bit 13 reads 1 exactly while the buffer holds at least one result.
- R5: Reads of address 4 return the stored results in arrival order, and each such read removes one result.
- R6: The buffer holds DEPTH (16) results. A result that arrives while the buffer is full, with no read in the same cycle, is dropped and sets status bit 9 (overflow). Bit 9 stays set until a flush.
- R7: A write of any data to address 3 empties the buffer and clears status bits 8 and 9, and a result arriving in the same cycle is discarded. The pending bit is left unchanged.
- R8: Control word bit 0 = 1 returns results in straight binary. Bit 0 = 0 inverts bit 11 of the word when it is read. Bits 15:12 of a result read are always zero.
- R9: `irq_o` is high exactly when control word bit 7, interrupt-gate word bit 7 and buffer-not-empty are all true.
- R10: A read of address 4 while the buffer is empty returns the word the last successful result read returned (0 after reset) and changes no state.
- R11: Status bits other than 13, 11, 9 and 8, including bit 14, read zero.
- R12: `conv_done_i` while no conversion is pending is ignored: nothing is stored and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write enable |
| rd_en_i | input | 1 | Bus read enable |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of `rd_en_i`, zero otherwise |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result |
| conv_start_o | output | 1 | Single-cycle conversion start pulse |
| irq_o | output | 1 | Level interrupt: results waiting and enabled |

## Verification
The hardest state to reach from the ports is a full buffer that receives a further result. That state needs sixteen accepted start/done pairs with no drain between them. The case where a full buffer is read in the same cycle that a result arrives is harder still, because that one result must be kept rather than dropped. A directed burst of seventeen conversions reaches overflow. After that, random stimulus with few reads and frequent completions keeps the buffer near full, so that reads, flushes and overlapping start strobes collide with arriving results. A bench model built from the requirements checks every cycle.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL  = 3'd0,
    ADR_IGATE = 3'd1,
    ADR_START = 3'd2,
    ADR_FLUSH = 3'd3,
    ADR_DATA  = 3'd4
  } reg_addr_e;

  // status bit positions decoded by software
  localparam int ST_OVERRUN  = 8;
  localparam int ST_OVERFLOW = 9;
  localparam int ST_PENDING  = 11;
  localparam int ST_AVAIL    = 13;

  // control word bits
  localparam int CB_STRAIGHT = 0;
  localparam int CB_IEN      = 7;
endpackage

// File: rtl/adc_acq_regs.sv
module adc_acq_regs
  import adc_acq_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              straight_o,
  output logic              irq_gate_o,
  output logic              start_o,
  output logic              flush_o
);
  logic ctrl_straight_q, ctrl_ien_q, igate_ien_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_straight_q <= 1'b0;
      ctrl_ien_q      <= 1'b0;
      igate_ien_q     <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_CTRL) begin
        ctrl_straight_q <= wdata_i[CB_STRAIGHT];
        ctrl_ien_q      <= wdata_i[CB_IEN];
      end
      if (addr_i == ADR_IGATE) igate_ien_q <= wdata_i[CB_IEN];
    end
  end

  // strobes: data is ignored
  assign start_o    = wr_en_i && (addr_i == ADR_START);
  assign flush_o    = wr_en_i && (addr_i == ADR_FLUSH);
  assign straight_o = ctrl_straight_q;
  assign irq_gate_o = ctrl_ien_q && igate_ien_q;
endmodule

// File: rtl/adc_acq_conv.sv
module adc_acq_conv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic flush_i,
  output logic pending_o,
  output logic overrun_o,
  output logic start_pulse_o,
  output logic push_o
);
  logic pending_q, overrun_q, pulse_q;
  logic accept;

  assign accept = start_i && (!pending_q || done_i);
  assign push_o = done_i && pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      overrun_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= accept;
      if (accept)       pending_q <= 1'b1;
      else if (push_o)  pending_q <= 1'b0;
      if (flush_i)                               overrun_q <= 1'b0;
      else if (start_i && pending_q && !done_i)  overrun_q <= 1'b1;
    end
  end

  assign pending_o     = pending_q;
  assign overrun_o     = overrun_q;
  assign start_pulse_o = pulse_q;
endmodule

// File: rtl/adc_acq_fifo.sv
module adc_acq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     count_o,
  output logic              overflow_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     count_q;
  logic              ovf_q;
  logic              do_pop, do_push, full;

  assign full    = (count_q == FULL_CNT);
  assign do_pop  = pop_i && (count_q != '0) && !flush_i;
  assign do_push = push_i && !flush_i && (!full || do_pop);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IX) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_push) wptr_q <= bump(wptr_q);
      if (do_pop)  rptr_q <= bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
      if (push_i && !do_push) ovf_q <= 1'b1;
    end
  end

  assign head_o     = mem_q[rptr_q];
  assign count_o    = count_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/adc_acq_front.sv
module adc_acq_front
  import adc_acq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SAMPLE_W = 12,
  parameter int BUS_W    = 16,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic                conv_done_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                conv_start_o,
  output logic                irq_o
);
  logic                straight, irq_gate, start_stb, flush_stb;
  logic                pending, overrun, push, overflow, pop;
  logic [SAMPLE_W-1:0] head, coded, last_q;
  logic [CW-1:0]       fifo_cnt;
  logic                avail;

  adc_acq_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .straight_o(straight), .irq_gate_o(irq_gate),
    .start_o(start_stb), .flush_o(flush_stb)
  );

  adc_acq_conv u_conv (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_stb), .done_i(conv_done_i),
    .flush_i(flush_stb), .pending_o(pending), .overrun_o(overrun),
    .start_pulse_o(conv_start_o), .push_o(push)
  );

  adc_acq_fifo #(.DEPTH(DEPTH), .DATA_W(SAMPLE_W)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .data_i(conv_data_i),
    .pop_i(pop), .flush_i(flush_stb), .head_o(head), .count_o(fifo_cnt),
    .overflow_o(overflow)
  );

  assign avail = (fifo_cnt != '0);
  assign pop   = rd_en_i && (addr_i == ADR_DATA) && avail;

  // two's-complement coding flips the sign bit on the way out
  always_comb begin
    coded = head;
    if (!straight) coded[SAMPLE_W-1] = ~head[SAMPLE_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= '0;
    else if (pop) last_q <= coded;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        ADR_CTRL: begin
          rdata_o[ST_AVAIL]    = avail;
          rdata_o[ST_PENDING]  = pending;
          rdata_o[ST_OVERFLOW] = overflow;
          rdata_o[ST_OVERRUN]  = overrun;
        end
        ADR_DATA: rdata_o[SAMPLE_W-1:0] = avail ? coded : last_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq_gate && avail;
endmodule

// File: rtl/adc_acq_front_chk.sv
module adc_acq_front_chk
  import adc_acq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              conv_done_i,
  input logic              conv_start_o,
  input logic              irq_o,
  input logic              pending,
  input logic              overflow,
  input logic              overrun,
  input logic [CW-1:0]     fifo_cnt
);
  logic flush_w, read_w;
  assign flush_w = wr_en_i && (addr_i == ADR_FLUSH);
  assign read_w  = rd_en_i && (addr_i == ADR_DATA);

  assert_pulse_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> pending);

  assert_overrun_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun && !flush_w |=> overrun);

  assert_no_overfill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH)) && conv_done_i && pending && !read_w && !flush_w |=> overflow);

  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> (fifo_cnt == '0) && !overflow && !overrun);

  assert_irq_needs_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (fifo_cnt != '0));

  assert_idle_done_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !pending && !read_w && !flush_w |=> $stable(fifo_cnt));
endmodule

bind adc_acq_front adc_acq_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .conv_done_i(conv_done_i), .conv_start_o(conv_start_o),
  .irq_o(irq_o), .pending(pending), .overflow(overflow), .overrun(overrun),
  .fifo_cnt(fifo_cnt)
);

// File: tb/sim_adc_acq_front.sv
module sim_adc_acq_front;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 0, rd_en_i = 0, conv_done_i = 0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [11:0] conv_data_i = '0;
  logic [15:0] rdata_o;
  logic        conv_start_o, irq_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  adc_acq_front u0 (.*);

  // bench model, built from the requirements
  logic [11:0] mq [DEPTH];
  int          mcnt;
  bit          m_pend, m_ovr, m_ovf, m_pulse, m_straight, m_cien, m_gien;
  logic [11:0] m_last;

  function automatic logic [15:0] code_word(input logic [11:0] v, input bit straight);
    return {4'h0, straight ? v[11] : ~v[11], v[10:0]};
  endfunction

  function automatic logic [15:0] status_word();
    logic [15:0] s = '0;
    s[13] = (mcnt != 0);
    s[11] = m_pend;
    s[9]  = m_ovf;
    s[8]  = m_ovr;
    return s;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                      input logic [15:0] wd, input bit dn, input logic [11:0] dd,
                      input string tag);
    bit pop, push, start, clr, acc;
    @(negedge clk_i);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = wd;
    conv_done_i = dn; conv_data_i = dd;
    #1;
    check("R9 irq", {15'd0, irq_o}, {15'd0, m_cien && m_gien && (mcnt != 0)});
    check("R2 start pulse", {15'd0, conv_start_o}, {15'd0, m_pulse});
    if (rd) begin
      if (a == 3'd0)      check(tag, rdata_o, status_word());
      else if (a == 3'd4) check(tag, rdata_o, (mcnt != 0) ? code_word(mq[0], m_straight) : {4'h0, m_last});
      else                check("R11 unmapped", rdata_o, 16'h0);
    end
    @(posedge clk_i);
    clr   = wr && a == 3'd3;
    start = wr && a == 3'd2;
    pop   = rd && a == 3'd4 && mcnt != 0;
    push  = dn && m_pend;
    acc   = start && (!m_pend || dn);
    if (start && m_pend && !dn) m_ovr = 1;
    m_pulse = acc;
    if (acc) m_pend = 1;
    else if (push) m_pend = 0;
    if (clr) begin
      mcnt = 0; m_ovf = 0; m_ovr = 0;
    end else begin
      bit room = (mcnt < DEPTH) || pop;
      if (pop) begin
        m_last = code_word(mq[0], m_straight)[11:0];
        for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (push) begin
        if (room) begin mq[mcnt] = dd; mcnt++; end
        else m_ovf = 1;
      end
    end
    if (wr && a == 3'd0) begin m_straight = wd[0]; m_cien = wd[7]; end
    if (wr && a == 3'd1) m_gien = wd[7];
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, ""); endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mcnt = 0; m_pend = 0; m_ovr = 0; m_ovf = 0; m_pulse = 0;
    m_straight = 0; m_cien = 0; m_gien = 0; m_last = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R1 reset state
    step(0, 1, 0, 0, 0, 0, "R1 status after reset");
    step(0, 1, 4, 0, 0, 0, "R10 empty read after reset");
    // R12 completion with nothing pending
    step(0, 0, 0, 0, 1, 12'h123, "");
    step(0, 1, 0, 0, 0, 0, "R12 status after idle done");
    // R2 start strobe, data ignored
    step(1, 0, 2, 16'hBEEF, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, "R2 pending set");
    // R3 overrun
    step(1, 0, 2, 16'h0000, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, "R3 overrun set");
    step(0, 0, 0, 0, 1, 12'hABC, "");
    step(0, 1, 0, 0, 0, 0, "R4 avail and pending cleared");
    step(0, 1, 0, 0, 0, 0, "R3 overrun still set");
    // R8 straight binary
    step(1, 0, 0, 16'h0001, 0, 0, "");
    step(0, 1, 4, 0, 0, 0, "R8 straight read");
    step(0, 1, 4, 0, 0, 0, "R10 empty read returns last");
    step(0, 1, 0, 0, 0, 0, "R10 status unchanged");
    // R8 two's complement, R9 interrupt gating
    step(1, 0, 0, 16'h0080, 0, 0, "");
    step(1, 0, 1, 16'h0080, 0, 0, "");
    step(1, 0, 2, 0, 0, 0, "");
    step(0, 0, 0, 0, 1, 12'h800, "");
    idle();
    step(1, 0, 1, 16'h0000, 0, 0, "R9 gate off");
    idle();
    step(0, 1, 4, 0, 0, 0, "R8 sign bit flipped");
    // R6 overflow with seventeen conversions
    for (int k = 0; k < DEPTH + 1; k++) begin
      step(1, 0, 2, 16'hFFFF, 0, 0, "");
      step(0, 0, 0, 0, 1, 12'(k * 37 + 5), "");
    end
    step(0, 1, 0, 0, 0, 0, "R6 overflow flagged");
    step(0, 1, 4, 0, 0, 0, "R5 first in order");
    step(0, 1, 4, 0, 0, 0, "R5 second in order");
    step(0, 1, 0, 0, 0, 0, "R6 overflow sticky");
    // R7 flush, data ignored
    step(1, 0, 3, 16'h1234, 0, 0, "");
    step(0, 1, 0, 0, 0, 0, "R7 status after flush");
    step(0, 1, 4, 0, 0, 0, "R7 flushed read returns last");
    step(0, 1, 6, 0, 0, 0, "R11 unmapped read");
    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      bit dn = ($urandom_range(0, 99) < 45);
      logic [11:0] dd = 12'($urandom);
      logic [15:0] wd = 16'($urandom);
      if (r < 30)      step(1, 0, 2, wd, dn, dd, "");
      else if (r < 33) step(1, 0, 3, wd, dn, dd, "");
      else if (r < 37) step(1, 0, 0, wd, dn, dd, "");
      else if (r < 41) step(1, 0, 1, wd, dn, dd, "");
      else if (r < 55) step(0, 1, 0, 0, dn, dd, "R11 status random");
      else if (r < 75) step(0, 1, 4, 0, dn, dd, "R5 data random");
      else             step(0, 0, 0, 0, dn, dd, "");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule